// File: doc/BRIEF.md
# Variable-Length Serial Control Port

This block is a four-wire serial slave that gives a host processor write access to the configuration of a two-channel audio encoder. It also lets the host read back the encoder's coefficient memories. The host pulls a select line low, shifts a two-byte header, then shifts data bytes. The header carries a read/write flag and a 10-bit address. The number of data bytes the block expects is not fixed: it follows from the address that arrived in the header. The serial clock, select and data inputs are synchronised into the block's own clock domain, so the serial clock may run without pause or stop between transactions.

Address bit 9 picks the channel, and address bit 8 separates the coefficient memory (256 words of 22 bits per channel) from that channel's small register group. The group holds an 11-bit control word and three 22-bit settings: output level, stereo spreading and dialog boost. A write takes effect only when its final bit has arrived. Reads are served from the coefficient memories only. During a read, the data-out line is enabled for as long as the host keeps the transaction open. A busy input from the boot sequencer shuts out any transaction that begins while it is high.

Top module: `vcp_ctl_port`

## Requirements
- R1: After reset, every control, level, spreading and dialog output is zero, and the data-out enable `sdo_oe_o` is low.
- R2: While `sel_ni` is low, the block samples `sdi_i` on each rising edge of `sclk_i`, MSB first. It reads 16 header bits: five don't-care bits, then the direction bit (0 = write, 1 = read), then address bits 9:8, then address bits 7:0.
- R3: Addresses 0–255 reach channel 0's coefficient memory and 512–767 reach channel 1's. Each access carries 3 data bytes, and a write stores the low 22 bits at address bits 7:0.
- R4: A read of a memory address returns 24 bits, MSB first: two zero bits, then the stored 22-bit word. `sdo_o` changes only on falling edges of `sclk_i`, and the first bit is valid from the falling edge after the 16th header bit.
- R5: Addresses 256 (channel 0) and 768 (channel 1) hold the control word. It is written with 2 data bytes, and the low 11 bits are stored.
- R6: Index 2, 3 and 4 within a channel's group (258–260, 770–772) hold the level, spreading and dialog settings. Each is written with 3 bytes, and the low 22 bits are stored.
- R7: Writes to reserved group indices (257, 769, and indices 5–255 of each group) change no output, and reads of them return zero.
- R8: A read of a write-only setting returns zero and leaves that setting unchanged.
- R9: `sdo_oe_o` rises only after the header of a read has been taken. It stays high until `sel_ni` returns high, and it is never high during a write.
- R10: If `sel_ni` rises before the last expected data bit, the write is discarded.
- R11: If `busy_i` is high when `sel_ni` falls, the whole transaction is ignored: nothing is written and `sdo_oe_o` stays low.
- R12: Edges of `sclk_i` while `sel_ni` is high have no effect, and the next transaction decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, at least 12x the serial bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Transaction select, active low |
| sclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Boot sequencer busy; blocks transactions that start while high |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for the external tri-state driver of `sdo_o` |
| ctrl_o | output | 2x11 | Control word per channel |
| level_o | output | 2x22 | Output level setting per channel |
| spread_o | output | 2x22 | Stereo spreading setting per channel |
| dialog_o | output | 2x22 | Dialog boost setting per channel |

## Verification
The bench uses the default widths: a 10-bit address, 22-bit words and an 11-bit control word, with two synchroniser stages. These values bring both transaction lengths within reach (32 bits for the control word, 40 bits for everything else). They also give both memory edges (0, 255, 512, 767), the padding bits above bit 21, and the split between channels on address bit 9. The serial clock runs at one twelfth of the block clock. This leaves room for the synchroniser delay before each sampling point, and the bench also checks early select release, the busy lockout and stray clock edges between transactions.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int unsigned HDR_BITS   = 16;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_LEVEL  = 2;
  localparam int unsigned REG_SPREAD = 3;
  localparam int unsigned REG_DIALOG = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_LEVEL, SEL_SPREAD, SEL_DIALOG
  } reg_sel_e;
endpackage

// File: rtl/vcp_sync.sv
module vcp_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) st_q[s] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/vcp_frame.sv
module vcp_frame
  import vcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 22,
  parameter int unsigned CTRL_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sel_ni,
  input  logic              sdi_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              active_o,
  output logic              ignore_o,
  output logic              sclk_fall_o
);
  localparam int unsigned IDX_W      = ADDR_W - 2;
  localparam int unsigned SH_W       = WORD_W - 1;
  localparam int unsigned CTRL_BYTES = (CTRL_W + 7) / 8;
  localparam int unsigned WORD_BYTES = (WORD_W + 7) / 8;
  localparam int unsigned BITS_CTRL  = HDR_BITS + 8 * CTRL_BYTES;
  localparam int unsigned BITS_WORD  = HDR_BITS + 8 * WORD_BYTES;
  localparam int unsigned CNT_W      = $clog2(BITS_WORD);
  localparam int unsigned RD_W       = 8 * WORD_BYTES;

  logic              sclk_q, act_q, act, rise, fall, start;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q, last_q;
  logic              hdr_q, done_q, rw_q, ign_q, loaded_q, oe_q;
  logic [RD_W-1:0]   out_q;
  logic [ADDR_W-1:0] hdr_addr;
  logic              hdr_rw, hdr_ctrl;
  logic [WORD_W-1:0] data_nx;

  assign act      = ~sel_ni;
  assign rise     = sclk_i & ~sclk_q;
  assign fall     = ~sclk_i & sclk_q;
  assign start    = act & ~act_q;
  assign hdr_addr = {sh_q[ADDR_W-2:0], sdi_i};
  assign hdr_rw   = sh_q[ADDR_W-1];
  assign hdr_ctrl = hdr_addr[ADDR_W-2] && (hdr_addr[IDX_W-1:0] == IDX_W'(REG_CTRL));
  assign data_nx  = {sh_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      act_q     <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      last_q    <= '0;
      hdr_q     <= 1'b0;
      done_q    <= 1'b0;
      rw_q      <= 1'b0;
      ign_q     <= 1'b0;
      loaded_q  <= 1'b0;
      oe_q      <= 1'b0;
      out_q     <= '0;
      addr_o    <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      sclk_q  <= sclk_i;
      act_q   <= act;
      wr_en_o <= 1'b0;
      if (!act) begin
        cnt_q    <= '0;
        hdr_q    <= 1'b0;
        done_q   <= 1'b0;
        oe_q     <= 1'b0;
        loaded_q <= 1'b0;
      end else begin
        if (start) ign_q <= busy_i;
        if (rise && !done_q) begin
          sh_q  <= {sh_q[SH_W-2:0], sdi_i};
          cnt_q <= cnt_q + 1'b1;
          if (!hdr_q && cnt_q == CNT_W'(HDR_BITS - 1)) begin
            hdr_q  <= 1'b1;
            addr_o <= hdr_addr;
            rw_q   <= hdr_rw;
            oe_q   <= hdr_rw & ~ign_q;
            last_q <= hdr_ctrl ? CNT_W'(BITS_CTRL - 1) : CNT_W'(BITS_WORD - 1);
          end
          if (hdr_q && cnt_q == last_q) begin
            done_q <= 1'b1;
            if (!rw_q && !ign_q) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= data_nx;
            end
          end
        end
        // first falling edge after the header loads, later ones shift
        if (fall && oe_q) begin
          if (!loaded_q) begin
            out_q    <= {{(RD_W-WORD_W){1'b0}}, rd_word_i};
            loaded_q <= 1'b1;
          end else begin
            out_q <= {out_q[RD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sdo_o       = out_q[RD_W-1];
  assign sdo_oe_o    = oe_q;
  assign active_o    = act;
  assign ignore_o    = ign_q;
  assign sclk_fall_o = fall;
endmodule

// File: rtl/vcp_param_mem.sv
module vcp_param_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned WORD_W = 22,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/vcp_chan_regs.sv
module vcp_chan_regs
  import vcp_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WORD_W = 22,
  parameter int unsigned CTRL_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] level_o,
  output logic [WORD_W-1:0] spread_o,
  output logic [WORD_W-1:0] dialog_o
);
  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if      (idx_i == IDX_W'(REG_CTRL))   sel = SEL_CTRL;
    else if (idx_i == IDX_W'(REG_LEVEL))  sel = SEL_LEVEL;
    else if (idx_i == IDX_W'(REG_SPREAD)) sel = SEL_SPREAD;
    else if (idx_i == IDX_W'(REG_DIALOG)) sel = SEL_DIALOG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      level_o  <= '0;
      spread_o <= '0;
      dialog_o <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_CTRL:   ctrl_o   <= data_i[CTRL_W-1:0];
        SEL_LEVEL:  level_o  <= data_i;
        SEL_SPREAD: spread_o <= data_i;
        SEL_DIALOG: dialog_o <= data_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vcp_ctl_port.sv
module vcp_ctl_port #(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned WORD_W      = 22,
  parameter int unsigned CTRL_W      = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sel_ni,
  input  logic                          sclk_i,
  input  logic                          sdi_i,
  input  logic                          busy_i,
  output logic                          sdo_o,
  output logic                          sdo_oe_o,
  output logic [1:0][CTRL_W-1:0]        ctrl_o,
  output logic [1:0][WORD_W-1:0]        level_o,
  output logic [1:0][WORD_W-1:0]        spread_o,
  output logic [1:0][WORD_W-1:0]        dialog_o
);
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned DEPTH  = 1 << IDX_W;

  logic              sel_s, sclk_s, sdi_s;
  logic              wr_en, frm_active, frm_ignore, frm_fall;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wr_data, rd_word;
  logic [NUM_CH-1:0][WORD_W-1:0] ram_rd;

  vcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_ni, sclk_i, sdi_i}),
    .q_o    ({sel_s, sclk_s, sdi_s})
  );

  vcp_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_s),
    .sel_ni      (sel_s),
    .sdi_i       (sdi_s),
    .busy_i      (busy_i),
    .rd_word_i   (rd_word),
    .wr_en_o     (wr_en),
    .addr_o      (addr),
    .wr_data_o   (wr_data),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o),
    .active_o    (frm_active),
    .ignore_o    (frm_ignore),
    .sclk_fall_o (frm_fall)
  );

  // addr[ADDR_W-1] picks the channel, addr[ADDR_W-2] picks registers over memory
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = (addr[ADDR_W-1] == 1'(ch));

    vcp_param_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en & hit & ~addr[ADDR_W-2]),
      .addr_i  (addr[IDX_W-1:0]),
      .wdata_i (wr_data),
      .rdata_o (ram_rd[ch])
    );

    vcp_chan_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en & hit & addr[ADDR_W-2]),
      .idx_i    (addr[IDX_W-1:0]),
      .data_i   (wr_data),
      .ctrl_o   (ctrl_o[ch]),
      .level_o  (level_o[ch]),
      .spread_o (spread_o[ch]),
      .dialog_o (dialog_o[ch])
    );
  end

  assign rd_word = addr[ADDR_W-2] ? '0 : ram_rd[addr[ADDR_W-1]];
endmodule

// File: rtl/vcp_ctl_port_chk.sv
module vcp_ctl_port_chk
  import vcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 22,
  parameter int unsigned CTRL_W = 11
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sdo_o,
  input logic                   sdo_oe_o,
  input logic                   active_i,
  input logic                   ignore_i,
  input logic                   fall_i,
  input logic                   wr_en_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [WORD_W-1:0]      wr_data_i,
  input logic [1:0][CTRL_W-1:0] ctrl_o,
  input logic [1:0][WORD_W-1:0] level_o,
  input logic [1:0][WORD_W-1:0] spread_o,
  input logic [1:0][WORD_W-1:0] dialog_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_LEVEL0 = {2'b01, IDX_W'(REG_LEVEL)};
  localparam logic [ADDR_W-1:0] A_CTRL1  = {2'b11, IDX_W'(REG_CTRL)};
  localparam logic [ADDR_W-1:0] A_RSVD0  = {2'b01, IDX_W'(1)};

  assert_oe_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> $past(active_i));

  assert_busy_no_oe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !ignore_i);

  assert_busy_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !ignore_i);

  assert_commit_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $past(active_i));

  assert_sdo_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdo_o));

  assert_level_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_LEVEL0) |=> level_o[0] == $past(wr_data_i));

  assert_ctrl_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CTRL1) |=> ctrl_o[1] == $past(wr_data_i[CTRL_W-1:0]));

  assert_reserved_inert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RSVD0) |=>
      ($stable(ctrl_o) && $stable(level_o) && $stable(spread_o) && $stable(dialog_o)));
endmodule

bind vcp_ctl_port vcp_ctl_port_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o),
  .active_i  (frm_active),
  .ignore_i  (frm_ignore),
  .fall_i    (frm_fall),
  .wr_en_i   (wr_en),
  .addr_i    (addr),
  .wr_data_i (wr_data),
  .ctrl_o    (ctrl_o),
  .level_o   (level_o),
  .spread_o  (spread_o),
  .dialog_o  (dialog_o)
);

// File: tb/tb_vcp_ctl_port.sv
`timescale 1ns/1ps
module tb_vcp_ctl_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic sdo, sdo_oe;
  logic [1:0][10:0] ctrl;
  logic [1:0][21:0] level, spread, dialog;

  int total = 0, bad = 0;
  logic [23:0] rd_data;
  logic oe_hdr, oe_dat;
  logic [159:0] snap;

  always #4 clk = ~clk;

  vcp_ctl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .busy_i(busy), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .ctrl_o(ctrl),
    .level_o(level), .spread_o(spread), .dialog_o(dialog)
  );

  // {addr, write data, expected, requirement}
  localparam logic [61:0] VECS [12] = '{
    {10'd0,   24'hFFFFFF, 24'h3FFFFF, 4'd3},  // R3 padding dropped, R4 readback
    {10'd255, 24'h123456, 24'h123456, 4'd3},  // R3 top of channel 0
    {10'd512, 24'h2AAAAA, 24'h2AAAAA, 4'd3},  // R3 channel 1 base
    {10'd767, 24'h155555, 24'h155555, 4'd4},  // R4 alternating bits
    {10'd256, 24'h00FFFF, 24'h0007FF, 4'd5},  // R5 ctrl, 2 bytes
    {10'd768, 24'h000485, 24'h000485, 4'd5},  // R5
    {10'd258, 24'hC00001, 24'h000001, 4'd6},  // R6 level ch0
    {10'd259, 24'h100000, 24'h100000, 4'd6},  // R6
    {10'd260, 24'h3FFFFF, 24'h3FFFFF, 4'd6},  // R6
    {10'd770, 24'h200000, 24'h200000, 4'd6},  // R6 level ch1
    {10'd771, 24'h00ABCD, 24'h00ABCD, 4'd6},  // R6
    {10'd772, 24'h012345, 24'h012345, 4'd6}   // R6
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [9:0] a);
    return (a[8] && a[7:0] == 8'd0) ? 2 : 3;
  endfunction

  function automatic logic [23:0] obs(input logic [9:0] a);
    case (a[7:0])
      8'd0: return {13'd0, ctrl[a[9]]};
      8'd2: return {2'd0, level[a[9]]};
      8'd3: return {2'd0, spread[a[9]]};
      8'd4: return {2'd0, dialog[a[9]]};
      default: return 24'd0;
    endcase
  endfunction

  function automatic logic [159:0] take_snap();
    return {6'd0, ctrl, level, spread, dialog};
  endfunction

  task automatic xfer(input logic rw, input logic [9:0] a, input int nb,
                      input logic [23:0] d, input int nclk);
    logic [15:0] hdr;
    int tot, lim;
    hdr = {5'b0, rw, a};
    tot = 16 + 8 * nb;
    lim = (nclk < tot) ? nclk : tot;
    rd_data = '0; oe_hdr = 1'b0; oe_dat = 1'b0;
    @(negedge clk); sel_n = 1'b0;
    wait_clks(6);
    for (int k = 0; k < lim; k++) begin
      sdi = (k < 16) ? hdr[15-k] : d[8*nb-1-(k-16)];
      wait_clks(6);
      if (k < 16) oe_hdr |= sdo_oe;
      else begin
        oe_dat |= sdo_oe;
        rd_data = {rd_data[22:0], sdo};
      end
      sclk = 1'b1;
      wait_clks(6);
      sclk = 1'b0;
    end
    wait_clks(6);
    sel_n = 1'b1;
    wait_clks(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] a;
    logic [23:0] d, e, got;
    logic [3:0] r;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    // R1 reset state
    chk("R1 regs", take_snap(), 160'd0);
    chk("R1 oe", {159'd0, sdo_oe}, 160'd0);

    for (int i = 0; i < 12; i++) begin
      {a, d, e, r} = VECS[i];
      xfer(1'b0, a, nbytes(a), d, 99);
      if (!a[8]) begin
        xfer(1'b1, a, 3, 24'd0, 99);
        got = rd_data;
      end else got = obs(a);
      chk($sformatf("R%0d vec %0d", r, i), {136'd0, got}, {136'd0, e});
    end

    // R2 address bit 9 separates channels at the same low address
    xfer(1'b0, 10'd1, 3, 24'h000011, 99);
    xfer(1'b0, 10'd513, 3, 24'h000022, 99);
    xfer(1'b1, 10'd1, 3, 24'd0, 99);
    chk("R2 ch0 word", {136'd0, rd_data}, {136'd0, 24'h000011});
    xfer(1'b1, 10'd513, 3, 24'd0, 99);
    chk("R2 ch1 word", {136'd0, rd_data}, {136'd0, 24'h000022});
    xfer(1'b1, 10'd0, 3, 24'd0, 99);
    chk("R3 ch0 untouched", {136'd0, rd_data}, {136'd0, 24'h3FFFFF});

    // R7 reserved writes and reads
    snap = take_snap();
    xfer(1'b0, 10'd257, 3, 24'hFFFFFF, 99);
    xfer(1'b0, 10'd769, 3, 24'hFFFFFF, 99);
    xfer(1'b0, 10'd261, 3, 24'hFFFFFF, 99);
    chk("R7 regs unchanged", take_snap(), snap);
    xfer(1'b1, 10'd257, 3, 24'd0, 99);
    chk("R7 read zero", {136'd0, rd_data}, {136'd0, 24'd0});

    // R8 write-only read, R9 enable window
    xfer(1'b1, 10'd258, 3, 24'd0, 99);
    chk("R8 read zero", {136'd0, rd_data}, {136'd0, 24'd0});
    chk("R8 level kept", {138'd0, level[0]}, {138'd0, 22'h000001});
    chk("R9 oe off in header", {159'd0, oe_hdr}, 160'd0);
    chk("R9 oe on in data", {159'd0, oe_dat}, 160'd1);
    chk("R9 oe off idle", {159'd0, sdo_oe}, 160'd0);
    xfer(1'b0, 10'd259, 3, 24'h100000, 99);
    chk("R9 oe off in write", {159'd0, oe_dat | oe_hdr}, 160'd0);

    // R10 early release
    xfer(1'b0, 10'd258, 3, 24'h2AAAAA, 39);
    chk("R10 level kept", {138'd0, level[0]}, {138'd0, 22'h000001});
    xfer(1'b0, 10'd256, 2, 24'h000000, 31);
    chk("R10 ctrl kept", {149'd0, ctrl[0]}, {149'd0, 11'h7FF});

    // R11 busy lockout
    busy = 1'b1;
    xfer(1'b0, 10'd259, 3, 24'h000000, 99);
    chk("R11 write blocked", {138'd0, spread[0]}, {138'd0, 22'h100000});
    xfer(1'b1, 10'd0, 3, 24'd0, 99);
    chk("R11 read blocked", {159'd0, oe_dat}, 160'd0);
    busy = 1'b0;

    // R12 stray clock edges while deselected
    snap = take_snap();
    sdi = 1'b1;
    for (int t = 0; t < 10; t++) begin
      sclk = 1'b1; wait_clks(6); sclk = 1'b0; wait_clks(6);
    end
    chk("R12 regs unchanged", take_snap(), snap);
    xfer(1'b0, 10'd260, 3, 24'h000777, 99);
    chk("R12 next frame", {138'd0, dialog[0]}, {138'd0, 22'h000777});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule